// File: doc/BRIEF.md
# Two-Channel Attenuation Ramp Controller

This block turns a requested attenuation and a mute request into the attenuation that each of two audio channels actually uses, one frame at a time. Every channel takes an 8-bit code in 0.5 dB steps. The block keeps a target level and a current level, both in 1/8 dB units. A 2-bit mode input sets how the current level follows the target. The level can jump at once. It can jump at the next zero crossing of that channel's signal. It can ramp by one 1/8 dB per frame. It can also ramp with each single step held until a zero crossing.

A crossing that never comes cannot hold a change forever. A per-channel frame counter forces the change once it expires. The two channels are fully independent. Each has its own crossing detector, its own target, counter and level. The output levels go to a gain stage downstream. That gain stage, the decibel-to-linear conversion and any register access all lie outside this block.

Top module: `vol_ramp_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both levels read 0 and both settled flags read 1.
- R2: A code c maps to a target of 4*c in 1/8 dB units. While mute is 1, the target of both channels is 1024, which is 128 dB and is the muted state.
- R3: State changes only at clock edges where frame_stb is 1. A target that is latched at one strobe starts to act on the level at the next strobe.
- R4: With mode 2'b00, the level takes the latched target at the next strobe.
- R5: With mode 2'b01, the whole change is applied at the first later strobe where that channel's sample is a crossing. A crossing means that the sample's sign bit (bit 23) differs from the sign bit of the previous strobe's sample, or that the sample is exactly zero.
- R6: With mode 2'b01 and no crossing, the change is applied at the TIMEOUT_FRAMES-th strobe after the target was latched.
- R7: With mode 2'b10, the level moves one unit (1/8 dB) per strobe toward the target.
- R8: With mode 2'b11, each one-unit step needs its own crossing or an expired count. The count restarts after every step.
- R9: When the target changes during a ramp, the ramp goes on from the present level toward the new target, with no jump.
- R10: A crossing or a code change on one channel has no effect on the other channel's level.
- R11: A channel's settled flag is 1 exactly when its level equals its latched target.
- R12: Entering and leaving mute follow the selected mode in the same way as code changes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse once per sample frame |
| smp_l | input | 24 | Left sample, signed, used for crossing detection |
| smp_r | input | 24 | Right sample, signed, used for crossing detection |
| code_l | input | 8 | Left attenuation code, 0.5 dB per LSB |
| code_r | input | 8 | Right attenuation code, 0.5 dB per LSB |
| mute | input | 1 | Drive both targets to full attenuation |
| mode | input | 2 | 00 at once, 01 crossing, 10 ramp, 11 ramp on crossings |
| lvl_l | output | 11 | Left current attenuation in 1/8 dB units |
| lvl_r | output | 11 | Right current attenuation in 1/8 dB units |
| settled_l | output | 1 | Left level equals left target |
| settled_r | output | 1 | Right level equals right target |

## Verification
The bench builds the block with TIMEOUT_FRAMES set to 16 instead of 1024. This puts a forced change after a silent stretch, and several timed-out ramp steps in the stepped-on-crossing mode, within a few dozen frames. Sample width and code width stay at their defaults, so sign detection on bit 23 and the mute level of 1024 are exercised exactly as built for use.

// File: rtl/vol_ramp_pkg.sv
// Package: shared types and constants for the attenuation ramp controller.
// Assumes level units of 1/8 dB and a code LSB of 0.5 dB (four level units).
package vol_ramp_pkg;
    localparam int CODE_W   = 8;
    localparam int CODE_SHL = 2;                   // code LSB = 4 level units
    localparam int LVL_W    = CODE_W + CODE_SHL + 1; // room for the mute level
    localparam logic [LVL_W-1:0] LVL_MUTE = LVL_W'(1024);

    typedef enum logic [1:0] {
        MODE_NOW     = 2'b00,
        MODE_ZC      = 2'b01,
        MODE_SOFT    = 2'b10,
        MODE_SOFT_ZC = 2'b11
    } vr_mode_e;
endpackage

// File: rtl/vr_zero_cross.sv
// Module: per-channel zero-crossing detector.
// Flags a crossing at a strobe when the sample is exactly zero or its sign
// differs from the sign seen at the previous strobe. Assumes frame_stb pulses
// once per frame; the remembered sign is updated only on the strobe.
module vr_zero_cross #(
    parameter int SAMP_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [SAMP_W-1:0] sample,
    output logic              crossing
);
    logic prev_neg_q;

    // Purpose: remember the sign of the last strobed sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_neg_q <= 1'b0;
        else if (frame_stb) prev_neg_q <= sample[SAMP_W-1];
    end

    // Purpose: report a crossing for the sample presented with this strobe.
    always_comb begin
        crossing = frame_stb &&
                   ((sample == '0) || (sample[SAMP_W-1] != prev_neg_q));
    end
endmodule

// File: rtl/vr_chan_level.sv
// Module: per-channel target, timeout counter and current level.
// On each strobe the level moves toward the target latched at an earlier
// strobe, as the mode says. The target input is latched in the same strobe.
// A new target restarts the counter, and so does every step in mode 11.
// Assumes that tgt_in never goes above LVL_MUTE.
module vr_chan_level
    import vol_ramp_pkg::*;
#(
    parameter int TIMEOUT_FRAMES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  vr_mode_e         mode,
    input  logic [LVL_W-1:0] tgt_in,
    input  logic             crossing,
    output logic [LVL_W-1:0] lvl,
    output logic             settled
);
    localparam int TMR_W = (TIMEOUT_FRAMES > 1) ? $clog2(TIMEOUT_FRAMES) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_FRAMES - 1);

    logic [LVL_W-1:0] tgt_q, lvl_q, lvl_d, stepped;
    logic [TMR_W-1:0] tmr_q;
    logic             fire, step_taken;

    // Purpose: a pending change may go ahead on a crossing or an expired count.
    always_comb fire = crossing || (tmr_q == TMR_LAST);

    // Purpose: one 1/8 dB step from the present level toward the target.
    always_comb begin
        if (lvl_q < tgt_q) stepped = lvl_q + LVL_W'(1);
        else               stepped = lvl_q - LVL_W'(1);
    end

    // Purpose: choose the next level from the mode.
    always_comb begin
        lvl_d      = lvl_q;
        step_taken = 1'b0;
        if (lvl_q != tgt_q) begin
            unique case (mode)
                MODE_NOW:     lvl_d = tgt_q;
                MODE_ZC:      if (fire) lvl_d = tgt_q;
                MODE_SOFT:    lvl_d = stepped;
                MODE_SOFT_ZC: if (fire) begin
                    lvl_d      = stepped;
                    step_taken = 1'b1;
                end
                default:      lvl_d = lvl_q;
            endcase
        end
    end

    // Purpose: latch the target, run the counter and advance the level on strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            lvl_q <= '0;
            tmr_q <= '0;
        end else if (frame_stb) begin
            lvl_q <= lvl_d;
            if (tgt_in != tgt_q) begin
                tgt_q <= tgt_in;
                tmr_q <= '0;
            end else if (step_taken) begin
                tmr_q <= '0;
            end else if (tmr_q != TMR_LAST) begin
                tmr_q <= tmr_q + TMR_W'(1);
            end
        end
    end

    assign lvl     = lvl_q;
    assign settled = (lvl_q == tgt_q);
endmodule

// File: rtl/vol_ramp_ctrl.sv
// Module: two-channel attenuation ramp controller (top).
// Maps codes and mute to per-channel targets and builds one crossing detector
// and one level tracker for each channel. Assumes frame_stb is a single-cycle
// pulse once per frame and that the inputs are steady at that edge.
module vol_ramp_ctrl
    import vol_ramp_pkg::*;
#(
    parameter int SAMP_W         = 24,
    parameter int TIMEOUT_FRAMES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [SAMP_W-1:0] smp_l,
    input  logic [SAMP_W-1:0] smp_r,
    input  logic [CODE_W-1:0] code_l,
    input  logic [CODE_W-1:0] code_r,
    input  logic              mute,
    input  logic [1:0]        mode,
    output logic [LVL_W-1:0]  lvl_l,
    output logic [LVL_W-1:0]  lvl_r,
    output logic              settled_l,
    output logic              settled_r
);
    localparam int N_CH = 2;

    logic [SAMP_W-1:0] samp_a [N_CH];
    logic [CODE_W-1:0] code_a [N_CH];
    logic [LVL_W-1:0]  lvl_a  [N_CH];
    logic [LVL_W-1:0]  tgt_a  [N_CH];
    logic              stl_a  [N_CH];
    logic              zc_a   [N_CH];
    vr_mode_e          mode_e;

    assign samp_a[0] = smp_l;
    assign samp_a[1] = smp_r;
    assign code_a[0] = code_l;
    assign code_a[1] = code_r;
    assign mode_e    = vr_mode_e'(mode);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        // Purpose: code-to-level mapping, with mute overriding it.
        always_comb begin
            if (mute) tgt_a[ch] = LVL_MUTE;
            else      tgt_a[ch] = {1'b0, code_a[ch], {CODE_SHL{1'b0}}};
        end

        vr_zero_cross #(.SAMP_W(SAMP_W)) zc_i (
            .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
            .sample(samp_a[ch]), .crossing(zc_a[ch])
        );

        vr_chan_level #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) lvl_i (
            .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mode(mode_e),
            .tgt_in(tgt_a[ch]), .crossing(zc_a[ch]),
            .lvl(lvl_a[ch]), .settled(stl_a[ch])
        );
    end

    assign lvl_l     = lvl_a[0];
    assign lvl_r     = lvl_a[1];
    assign settled_l = stl_a[0];
    assign settled_r = stl_a[1];
endmodule

// File: rtl/vol_ramp_ctrl_chk.sv
// Module: assertion checker for vol_ramp_ctrl, bound to every instance.
// Watches only the ports. Assumes reset is applied from time zero.
module vol_ramp_ctrl_chk
    import vol_ramp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             frame_stb,
    input logic [1:0]       mode,
    input logic [LVL_W-1:0] lvl_l,
    input logic [LVL_W-1:0] lvl_r,
    input logic             settled_l,
    input logic             settled_r
);
    // R1: reset leaves both channels at 0 and settled
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (lvl_l == '0 && lvl_r == '0 && settled_l && settled_r));

    // R3: the levels hold between strobes
    a_r3_hold_off_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(lvl_l) && $stable(lvl_r)));

    // R7: a soft-ramp strobe moves a level by at most one unit
    a_r7_single_step_l: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mode == 2'b10) |=>
        ({1'b0, lvl_l} == {1'b0, $past(lvl_l)} ||
         {1'b0, lvl_l} == {1'b0, $past(lvl_l)} + 12'd1 ||
         {1'b0, lvl_l} + 12'd1 == {1'b0, $past(lvl_l)}));

    a_r7_single_step_r: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mode == 2'b10) |=>
        ({1'b0, lvl_r} == {1'b0, $past(lvl_r)} ||
         {1'b0, lvl_r} == {1'b0, $past(lvl_r)} + 12'd1 ||
         {1'b0, lvl_r} + 12'd1 == {1'b0, $past(lvl_r)}));

    // R2: no level goes beyond the mute level
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_l <= LVL_MUTE && lvl_r <= LVL_MUTE));
endmodule

bind vol_ramp_ctrl vol_ramp_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mode(mode),
    .lvl_l(lvl_l), .lvl_r(lvl_r), .settled_l(settled_l), .settled_r(settled_r)
);

// File: tb/vol_ramp_ctrl_tb_top.sv
// Scoreboard bench: the frame driver works out the expected outputs from the
// requirements and queues them. The monitor checks them after every strobe.
module vol_ramp_ctrl_tb_top;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic signed [23:0] smp_l = '0, smp_r = '0;
    logic [7:0] code_l = '0, code_r = '0;
    logic mute = 1'b0;
    logic [1:0] mode = 2'b10;
    logic [10:0] lvl_l, lvl_r;
    logic settled_l, settled_r;

    always #2.5 clk = ~clk;

    vol_ramp_ctrl #(.SAMP_W(24), .TIMEOUT_FRAMES(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .smp_l(smp_l), .smp_r(smp_r), .code_l(code_l), .code_r(code_r),
        .mute(mute), .mode(mode), .lvl_l(lvl_l), .lvl_r(lvl_r),
        .settled_l(settled_l), .settled_r(settled_r)
    );

    int total = 0, bad = 0;
    string cur_req = "R1";
    logic [23:0] exp_q[$];
    string tag_q[$];
    logic pend = 1'b0;

    // reference state per channel
    int  m_lvl[2], m_tgt[2], m_tmr[2];
    bit  m_neg[2];

    task automatic model_ch(input int ch, input logic signed [23:0] s, input int code);
        int  newt;
        bit  zc, fire, stp;
        newt = mute ? 1024 : code * 4;
        zc   = (s == 0) || (s[23] != m_neg[ch]);
        fire = zc || (m_tmr[ch] == TO - 1);
        stp  = 1'b0;
        if (m_lvl[ch] != m_tgt[ch]) begin
            case (mode)
                2'b00: m_lvl[ch] = m_tgt[ch];
                2'b01: if (fire) m_lvl[ch] = m_tgt[ch];
                2'b10: m_lvl[ch] += (m_lvl[ch] < m_tgt[ch]) ? 1 : -1;
                default: if (fire) begin
                    m_lvl[ch] += (m_lvl[ch] < m_tgt[ch]) ? 1 : -1;
                    stp = 1'b1;
                end
            endcase
        end
        if (newt != m_tgt[ch]) begin
            m_tgt[ch] = newt;
            m_tmr[ch] = 0;
        end else if (stp) m_tmr[ch] = 0;
        else if (m_tmr[ch] != TO - 1) m_tmr[ch]++;
        m_neg[ch] = s[23];
    endtask

    task automatic do_frame(input logic signed [23:0] sl, input logic signed [23:0] sr);
        @(negedge clk);
        smp_l = sl;
        smp_r = sr;
        frame_stb = 1'b1;
        model_ch(0, sl, int'(code_l));
        model_ch(1, sr, int'(code_r));
        exp_q.push_back({m_lvl[0][10:0], m_lvl[1][10:0],
                         m_lvl[0] == m_tgt[0], m_lvl[1] == m_tgt[1]});
        tag_q.push_back(cur_req);
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic frames(input int n, input logic signed [23:0] sl, input logic signed [23:0] sr);
        for (int i = 0; i < n; i++) do_frame(sl, sr);
    endtask

    // monitor: note a strobe edge, compare at the following falling edge
    always @(posedge clk) pend <= frame_stb;

    always @(negedge clk) begin
        if (pend) begin
            logic [23:0] got, exp;
            string tg;
            got = {lvl_l, lvl_r, settled_l, settled_r};
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty (R3) actual=%h expected=none", got);
            end else begin
                exp = exp_q.pop_front();
                tg  = tag_q.pop_front();
                if (got !== exp) begin
                    bad++;
                    $display("FAIL %s lvl_l/lvl_r/stl: actual=%0d/%0d/%b%b expected=%0d/%0d/%b%b",
                             tg, got[23:13], got[12:2], got[1], got[0],
                             exp[23:13], exp[12:2], exp[1], exp[0]);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired (R3) actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_lvl[c] = 0; m_tgt[c] = 0; m_tmr[c] = 0; m_neg[c] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        total++;
        if (lvl_l !== 11'd0 || lvl_r !== 11'd0 || settled_l !== 1'b1 || settled_r !== 1'b1) begin
            bad++;
            $display("FAIL R1 reset actual=%0d/%0d/%b%b expected=0/0/11",
                     lvl_l, lvl_r, settled_l, settled_r);
        end

        // R3: a code change with no strobe leaves the levels alone
        code_l = 8'd50;
        repeat (3) @(negedge clk);
        total++;
        if (lvl_l !== 11'd0) begin
            bad++;
            $display("FAIL R3 no strobe actual=%0d expected=0", lvl_l);
        end

        cur_req = "R4 R2 R11";
        mode = 2'b00; code_l = 8'd10; code_r = 8'd3;
        frames(3, 24'sd100, 24'sd100);

        cur_req = "R5 R11";
        mode = 2'b01; code_l = 8'd20;
        frames(3, 24'sd100, 24'sd100);
        do_frame(-24'sd50, 24'sd100);
        code_l = 8'd4;
        frames(2, -24'sd7, -24'sd7);
        do_frame(24'sd0, -24'sd7);

        cur_req = "R6";
        code_r = 8'd50;
        frames(20, 24'sd9, 24'sd9);

        cur_req = "R10";
        code_l = 8'd30; code_r = 8'd60;
        frames(2, 24'sd5, 24'sd5);
        do_frame(-24'sd5, 24'sd5);
        do_frame(-24'sd5, -24'sd5);

        cur_req = "R7 R11";
        mode = 2'b10; code_l = 8'd28; code_r = 8'd62;
        frames(12, 24'sd3, 24'sd3);
        cur_req = "R9";
        code_l = 8'd26; code_r = 8'd61;
        frames(20, 24'sd3, 24'sd3);

        cur_req = "R8";
        mode = 2'b11; code_l = 8'd24; code_r = 8'd64;
        for (int i = 0; i < 4; i++) do_frame((i % 2) ? 24'sd4 : -24'sd4, 24'sd4);
        frames(40, 24'sd4, 24'sd4);

        cur_req = "R12";
        mode = 2'b00; code_l = 8'd255; code_r = 8'd0;
        frames(2, 24'sd4, 24'sd4);
        mode = 2'b10; mute = 1'b1;
        frames(8, 24'sd4, 24'sd4);
        mute = 1'b0;
        frames(3, 24'sd4, 24'sd4);
        mode = 2'b00; mute = 1'b1;
        frames(2, 24'sd4, 24'sd4);

        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R3 outstanding items actual=%0d expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule